// File: doc/BRIEF.md
# Nibble-Memory Call Stack Engine

This block manages the hardware stack of a small CPU whose data memory is four bits wide. When the CPU calls a subroutine or takes an interrupt, the block saves the return address, and for an interrupt the status word as well, onto a stack held in data memory. On a return it reads them back and hands the restored values to the CPU. It also saves and restores the pair of bank-select fields on explicit request. It holds the 8-bit stack pointer, drives a nibble-wide RAM port, and moves one nibble per clock cycle.

The stack grows downwards and always occupies bank 0 of data memory. Every stored byte takes two nibble locations, so the pointer always moves in steps of two and its lowest bit always reads as zero. The pointer is decremented before each write. Loading it with 00H therefore places the first stored nibble at 0FFH, and address arithmetic wraps modulo 256. While a multi-nibble sequence runs, a busy flag is high. Command strobes and pointer writes that arrive during that time are dropped.

Top module: `nibstack_engine`

## Requirements
- R1: After reset the stack pointer reads 00H. A pointer write that is accepted stores the written value with bit 0 cleared, and `sp_rd_data` shows it from the cycle after the write.
- R2: Every stack access drives `ram_addr[11:8]` to 0 (bank 0). `ram_addr[7:0]` carries the nibble location.
- R3: Push addressing pre-decrements. The k-th nibble of a push (k counted from 0) is written at (SP-1-k) mod 256, so with SP=00H the first nibble goes to 0FFH. When the push ends, SP has dropped by twice the number of bytes pushed.
- R4: A call writes four nibbles in this order: {0, pc[14:12]}, pc[11:8], pc[7:4], pc[3:0]. SP then drops by 4.
- R5: An interrupt writes the four call nibbles, then psw[7:4], then psw[3:0]. SP then drops by 6.
- R6: A return reads locations SP+0 through SP+3 and restores pc = {n3[2:0], n2, n1, n0}, where n3 is the nibble read at SP+3. The padding bit n3[3] is ignored. `pc_load` pulses for one cycle in the cycle after the last read. SP then rises by 4.
- R7: A return from interrupt reads six nibbles. It restores psw = {n1, n0} and pc = {n5[2:0], n4, n3, n2}, raises `pc_load` and `psw_load` together in the cycle after the last read, and raises SP by 6.
- R8: Push-SB writes smb at SP-1 and srb at SP-2 and lowers SP by 2. Pop-SB reads srb at SP and smb at SP+1, pulses `sb_load` in the cycle after the second read, and raises SP by 2.
- R9: The first nibble access occurs in the cycle after the clock edge that accepts a command. Each following cycle carries one more nibble. `busy` is high in exactly those access cycles. `ram_we` and `ram_re` are low whenever `busy` is low.
- R10: While `busy` is high, command strobes and pointer writes are ignored.
- R11: When several strobes are high in the same idle cycle, one command is taken in this priority: interrupt, call, return-from-interrupt, return, push-SB, pop-SB. A command strobe takes precedence over a pointer write in the same cycle, and the pointer write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sp_wr_en | input | 1 | Stack pointer write strobe |
| sp_wr_data | input | 8 | Stack pointer write value |
| sp_rd_data | output | 8 | Stack pointer value, bit 0 always 0 |
| int_req | input | 1 | Interrupt entry: push PC and status word |
| call_req | input | 1 | Subroutine call: push PC |
| reti_req | input | 1 | Return from interrupt: pop status word and PC |
| ret_req | input | 1 | Subroutine return: pop PC |
| push_sb_req | input | 1 | Push bank-select pair |
| pop_sb_req | input | 1 | Pop bank-select pair |
| pc_in | input | 15 | Program counter to save |
| psw_in | input | 8 | Status word to save |
| smb_in | input | 4 | Memory bank select to save |
| srb_in | input | 4 | Register bank select to save |
| busy | output | 1 | Sequence in progress |
| ram_we | output | 1 | Nibble write strobe |
| ram_re | output | 1 | Nibble read strobe |
| ram_addr | output | 12 | Nibble address, bank in bits 11:8 |
| ram_wdata | output | 4 | Nibble write data |
| ram_rdata | input | 4 | Nibble read data, valid in the same cycle |
| pc_out | output | 15 | Restored program counter |
| psw_out | output | 8 | Restored status word |
| smb_out | output | 4 | Restored memory bank select |
| srb_out | output | 4 | Restored register bank select |
| pc_load | output | 1 | One-cycle pulse: pc_out is valid |
| psw_load | output | 1 | One-cycle pulse: psw_out is valid |
| sb_load | output | 1 | One-cycle pulse: smb_out and srb_out are valid |

## Verification
A command strobe is taken at one edge. Its nibble k appears on the RAM port k+1 cycles later. The pointer update and the restore pulses appear one cycle after the last nibble access, so a pop of n nibbles produces its load pulse n+1 cycles after the accepting edge. The bench keeps a behavioural model that is advanced at each rising edge from the same inputs. It compares every output against the model at each falling edge, so every result is checked in the exact cycle it becomes due. Strobes and pointer writes placed inside busy windows check that nothing leaks through.

// File: rtl/nibstack_pkg.sv
package nibstack_pkg;
  localparam int SP_W    = 8;
  localparam int NIB_W   = 4;
  localparam int PC_W    = 15;
  localparam int PSW_W   = 8;
  localparam int FRAME_W = 1 + PC_W + PSW_W;   // padded PC plus status word
  localparam int CNT_W   = 3;

  typedef enum logic [2:0] {
    OP_NONE, OP_CALL, OP_INT, OP_RET, OP_RETI, OP_PSB, OP_POPSB
  } op_e;

  typedef struct packed {
    logic int_r;
    logic call_r;
    logic reti_r;
    logic ret_r;
    logic psb_r;
    logic popsb_r;
  } req_t;

  // fixed priority among simultaneous strobes
  function automatic op_e pick_op(req_t r);
    if (r.int_r)        return OP_INT;
    else if (r.call_r)  return OP_CALL;
    else if (r.reti_r)  return OP_RETI;
    else if (r.ret_r)   return OP_RET;
    else if (r.psb_r)   return OP_PSB;
    else if (r.popsb_r) return OP_POPSB;
    return OP_NONE;
  endfunction

  function automatic logic op_push(op_e o);
    return (o == OP_CALL) || (o == OP_INT) || (o == OP_PSB);
  endfunction

  function automatic logic [CNT_W-1:0] op_len(op_e o);
    case (o)
      OP_CALL, OP_RET:   return CNT_W'(4);
      OP_INT, OP_RETI:   return CNT_W'(6);
      OP_PSB, OP_POPSB:  return CNT_W'(2);
      default:           return CNT_W'(1);
    endcase
  endfunction

  // push: pre-decrement below the pointer; pop: upward from the pointer
  function automatic logic [SP_W-1:0] nib_addr(op_e o, logic [SP_W-1:0] sp,
                                               logic [CNT_W-1:0] idx);
    if (op_push(o)) return sp - SP_W'(1) - SP_W'(idx);
    return sp + SP_W'(idx);
  endfunction

  function automatic logic [SP_W-1:0] sp_after(op_e o, logic [SP_W-1:0] sp);
    if (op_push(o)) return sp - SP_W'(op_len(o));
    return sp + SP_W'(op_len(o));
  endfunction
endpackage

// File: rtl/nibstack_ptr.sv
module nibstack_ptr
  import nibstack_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SP_W-1:0] wr_val,
  input  logic            step_en,
  input  logic [SP_W-1:0] step_val,
  output logic [SP_W-1:0] sp
);
  logic [SP_W-1:1] sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp_q <= '0;
    else if (step_en) sp_q <= step_val[SP_W-1:1];
    else if (wr_en)   sp_q <= wr_val[SP_W-1:1];
  end

  assign sp = {sp_q, 1'b0};
endmodule

// File: rtl/nibstack_seq.sv
module nibstack_seq
  import nibstack_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  req_t             req,
  input  logic [SP_W-1:0]  sp,
  input  logic [PC_W-1:0]  pc_in,
  input  logic [PSW_W-1:0] psw_in,
  input  logic [NIB_W-1:0] smb_in,
  input  logic [NIB_W-1:0] srb_in,
  output logic             busy,
  output op_e              op,
  output logic             ram_we,
  output logic             ram_re,
  output logic [SP_W-1:0]  nib_loc,
  output logic [NIB_W-1:0] wdata,
  output logic             seq_done,
  output logic [SP_W-1:0]  sp_next
);
  op_e                picked;
  op_e                op_q;
  logic [CNT_W-1:0]   idx_q;
  logic [FRAME_W-1:0] frame_q;
  logic               last_nib;
  logic               accept;

  assign picked   = pick_op(req);
  assign busy     = (op_q != OP_NONE);
  assign accept   = !busy && (picked != OP_NONE);
  assign last_nib = (idx_q == op_len(op_q) - CNT_W'(1));
  assign op       = op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_NONE;
      idx_q   <= '0;
      frame_q <= '0;
    end else if (accept) begin
      op_q  <= picked;
      idx_q <= '0;
      if (picked == OP_PSB) frame_q <= {smb_in, srb_in, {(FRAME_W-2*NIB_W){1'b0}}};
      else                  frame_q <= {1'b0, pc_in, psw_in};
    end else if (busy) begin
      frame_q <= frame_q << NIB_W;
      if (last_nib) op_q  <= OP_NONE;
      else          idx_q <= idx_q + CNT_W'(1);
    end
  end

  assign ram_we   = busy && op_push(op_q);
  assign ram_re   = busy && !op_push(op_q);
  assign nib_loc  = nib_addr(op_q, sp, idx_q);
  assign wdata    = frame_q[FRAME_W-1 -: NIB_W];
  assign seq_done = busy && last_nib;
  assign sp_next  = sp_after(op_q, sp);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ram_we && !ram_re)); // R9
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && $past(ram_we)) |-> (nib_loc == $past(nib_loc) - SP_W'(1))); // R3
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_re && $past(ram_re)) |-> (nib_loc == $past(nib_loc) + SP_W'(1))); // R6
endmodule

// File: rtl/nibstack_unpack.sv
module nibstack_unpack
  import nibstack_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [NIB_W-1:0] rdata,
  input  logic             done,
  input  op_e              op,
  output logic [PC_W-1:0]  pc_out,
  output logic [PSW_W-1:0] psw_out,
  output logic [NIB_W-1:0] smb_out,
  output logic [NIB_W-1:0] srb_out,
  output logic             pc_load,
  output logic             psw_load,
  output logic             sb_load
);
  logic [FRAME_W-1:0] acc_q;
  logic [FRAME_W-1:0] acc_nxt;

  // nibbles arrive lowest first; each new one enters at the top
  assign acc_nxt = {rdata, acc_q[FRAME_W-1:NIB_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      pc_out   <= '0;
      psw_out  <= '0;
      smb_out  <= '0;
      srb_out  <= '0;
      pc_load  <= 1'b0;
      psw_load <= 1'b0;
      sb_load  <= 1'b0;
    end else begin
      pc_load  <= 1'b0;
      psw_load <= 1'b0;
      sb_load  <= 1'b0;
      if (rd_en) acc_q <= acc_nxt;
      if (done && rd_en) begin
        case (op)
          OP_RET: begin
            pc_out  <= acc_nxt[FRAME_W-2 -: PC_W];
            pc_load <= 1'b1;
          end
          OP_RETI: begin
            pc_out   <= acc_nxt[FRAME_W-2 -: PC_W];
            psw_out  <= acc_nxt[PSW_W-1:0];
            pc_load  <= 1'b1;
            psw_load <= 1'b1;
          end
          OP_POPSB: begin
            smb_out <= acc_nxt[FRAME_W-1 -: NIB_W];
            srb_out <= acc_nxt[FRAME_W-NIB_W-1 -: NIB_W];
            sb_load <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_LOAD_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load || sb_load) |-> $past(done)); // R6
  AST_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_load, sb_load})); // R8
  AST_PSW_WITH_PC: assert property (@(posedge clk) disable iff (!rst_n)
    psw_load |-> pc_load); // R7
endmodule

// File: rtl/nibstack_engine.sv
module nibstack_engine
  import nibstack_pkg::*;
#(
  parameter int BANK_W     = 4,
  parameter int STACK_BANK = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sp_wr_en,
  input  logic [7:0]           sp_wr_data,
  output logic [7:0]           sp_rd_data,
  input  logic                 int_req,
  input  logic                 call_req,
  input  logic                 reti_req,
  input  logic                 ret_req,
  input  logic                 push_sb_req,
  input  logic                 pop_sb_req,
  input  logic [14:0]          pc_in,
  input  logic [7:0]           psw_in,
  input  logic [3:0]           smb_in,
  input  logic [3:0]           srb_in,
  output logic                 busy,
  output logic                 ram_we,
  output logic                 ram_re,
  output logic [11:0]          ram_addr,
  output logic [3:0]           ram_wdata,
  input  logic [3:0]           ram_rdata,
  output logic [14:0]          pc_out,
  output logic [7:0]           psw_out,
  output logic [3:0]           smb_out,
  output logic [3:0]           srb_out,
  output logic                 pc_load,
  output logic                 psw_load,
  output logic                 sb_load
);
  localparam int ADDR_W = BANK_W + SP_W;
  localparam logic [BANK_W-1:0] BANK_SEL = BANK_W'(STACK_BANK);

  req_t            req;
  op_e             cur_op;
  logic [SP_W-1:0] sp;
  logic [SP_W-1:0] nib_loc;
  logic [SP_W-1:0] sp_next;
  logic            seq_done;
  logic            sp_wr_ok;
  logic [ADDR_W-1:0] full_addr;

  assign req      = '{int_r: int_req, call_r: call_req, reti_r: reti_req,
                      ret_r: ret_req, psb_r: push_sb_req, popsb_r: pop_sb_req};
  assign sp_wr_ok = sp_wr_en && !busy && (req == '0);

  nibstack_ptr u_ptr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(sp_wr_ok), .wr_val(sp_wr_data),
    .step_en(seq_done), .step_val(sp_next),
    .sp(sp)
  );

  nibstack_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .sp(sp),
    .pc_in(pc_in), .psw_in(psw_in), .smb_in(smb_in), .srb_in(srb_in),
    .busy(busy), .op(cur_op), .ram_we(ram_we), .ram_re(ram_re),
    .nib_loc(nib_loc), .wdata(ram_wdata), .seq_done(seq_done),
    .sp_next(sp_next)
  );

  nibstack_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .rd_en(ram_re), .rdata(ram_rdata),
    .done(seq_done), .op(cur_op),
    .pc_out(pc_out), .psw_out(psw_out), .smb_out(smb_out), .srb_out(srb_out),
    .pc_load(pc_load), .psw_load(psw_load), .sb_load(sb_load)
  );

  assign full_addr  = {BANK_SEL, nib_loc};
  assign ram_addr   = full_addr;
  assign sp_rd_data = sp;

  AST_SP_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp_rd_data) |-> $past(sp_wr_ok || seq_done)); // R10
  AST_SP_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(seq_done)) |-> $stable(sp_rd_data)); // R10
  AST_SP_EVEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(seq_done) |-> (sp_rd_data[0] == 1'b0)); // R1
endmodule

// File: tb/nibstack_engine_tb.sv
module nibstack_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        sp_wr_en = 0;
  logic [7:0]  sp_wr_data = 0;
  logic [5:0]  strb = 0;   // {int, call, reti, ret, push_sb, pop_sb}
  logic [14:0] pc_in = 0;
  logic [7:0]  psw_in = 0;
  logic [3:0]  smb_in = 0, srb_in = 0;
  logic [7:0]  sp_rd_data;
  logic        busy, ram_we, ram_re, pc_load, psw_load, sb_load;
  logic [11:0] ram_addr;
  logic [3:0]  ram_wdata, ram_rdata, smb_out, srb_out;
  logic [14:0] pc_out;
  logic [7:0]  psw_out;
  logic [3:0]  mem [256];

  assign ram_rdata = mem[ram_addr[7:0]];

  nibstack_engine dut_i (
    .clk(clk), .rst_n(rst_n), .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
    .sp_rd_data(sp_rd_data), .int_req(strb[5]), .call_req(strb[4]),
    .reti_req(strb[3]), .ret_req(strb[2]), .push_sb_req(strb[1]),
    .pop_sb_req(strb[0]), .pc_in(pc_in), .psw_in(psw_in), .smb_in(smb_in),
    .srb_in(srb_in), .busy(busy), .ram_we(ram_we), .ram_re(ram_re),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .pc_out(pc_out), .psw_out(psw_out), .smb_out(smb_out), .srb_out(srb_out),
    .pc_load(pc_load), .psw_load(psw_load), .sb_load(sb_load)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { bit we; int loc; int d; } step_t;
  step_t q[$];
  int    m_sp = 0, m_delta = 0;
  string m_tag = "R9";
  int    m_kind = 0;            // 1 ret, 2 reti, 3 pop-sb, 0 none
  int    r_pc = 0, r_psw = 0, r_smb = 0, r_srb = 0;
  bit    e_pcl = 0, e_pswl = 0, e_sbl = 0;

  task automatic plan_push(input int nibs[$]);
    foreach (nibs[k]) q.push_back('{1'b1, (m_sp - 1 - k) & 255, nibs[k]});
    m_delta = -nibs.size();
  endtask

  task automatic plan_pop(input int n);
    for (int k = 0; k < n; k++) q.push_back('{1'b0, (m_sp + k) & 255, 0});
    m_delta = n;
  endtask

  function automatic int rd(input int k);
    return int'(mem[(m_sp + k) & 255]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_sp = 0; e_pcl = 0; e_pswl = 0; e_sbl = 0;
    end else begin
      e_pcl = 0; e_pswl = 0; e_sbl = 0;
      if (q.size() > 0) begin
        step_t s;
        s = q.pop_front();
        if (s.we) mem[s.loc] = 4'(s.d);
        if (q.size() == 0) begin
          m_sp = (m_sp + m_delta) & 255;
          e_pcl  = (m_kind == 1) || (m_kind == 2);
          e_pswl = (m_kind == 2);
          e_sbl  = (m_kind == 3);
        end
      end else if (strb != 0) begin
        m_kind = 0;
        if (strb[5] || strb[4]) begin
          int n[$];
          n = '{pc_in[14:12], pc_in[11:8], pc_in[7:4], pc_in[3:0]};
          if (strb[5]) begin n.push_back(psw_in[7:4]); n.push_back(psw_in[3:0]); m_tag = "R5"; end
          else m_tag = "R4";
          plan_push(n);
        end else if (strb[3]) begin
          m_tag = "R7"; m_kind = 2;
          r_psw = rd(1) * 16 + rd(0);
          r_pc  = ((rd(5) & 7) << 12) | (rd(4) << 8) | (rd(3) << 4) | rd(2);
          plan_pop(6);
        end else if (strb[2]) begin
          m_tag = "R6"; m_kind = 1;
          r_pc  = ((rd(3) & 7) << 12) | (rd(2) << 8) | (rd(1) << 4) | rd(0);
          plan_pop(4);
        end else if (strb[1]) begin
          m_tag = "R8";
          plan_push('{int'(smb_in), int'(srb_in)});
        end else begin
          m_tag = "R8"; m_kind = 3;
          r_srb = rd(0); r_smb = rd(1);
          plan_pop(2);
        end
      end else if (sp_wr_en) begin
        m_sp = sp_wr_data & 8'hFE;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (q.size() > 0), "R9", "busy", busy, q.size() > 0);
      chk(sp_rd_data == 8'(m_sp), "R1", "sp", sp_rd_data, m_sp);
      if (q.size() > 0) begin
        chk(ram_we == q[0].we && ram_re == !q[0].we, m_tag, "we/re", {ram_we, ram_re}, {q[0].we, !q[0].we});
        chk(ram_addr == {4'h0, 8'(q[0].loc)}, q[0].we ? "R3" : m_tag, "addr", ram_addr, q[0].loc);
        chk(ram_addr[11:8] == 4'h0, "R2", "bank", ram_addr[11:8], 0);
        if (q[0].we) chk(ram_wdata == 4'(q[0].d), m_tag, "wdata", ram_wdata, q[0].d);
      end else begin
        chk(!ram_we && !ram_re, "R9", "idle strobes", {ram_we, ram_re}, 0);
      end
      chk(pc_load == e_pcl && psw_load == e_pswl && sb_load == e_sbl, m_tag, "loads",
          {pc_load, psw_load, sb_load}, {e_pcl, e_pswl, e_sbl});
      if (e_pcl)  chk(pc_out == 15'(r_pc), m_tag, "pc_out", pc_out, r_pc);
      if (e_pswl) chk(psw_out == 8'(r_psw), "R7", "psw_out", psw_out, r_psw);
      if (e_sbl)  chk(smb_out == 4'(r_smb) && srb_out == 4'(r_srb), "R8", "sb_out",
                      {smb_out, srb_out}, {4'(r_smb), 4'(r_srb)});
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic [5:0] s, input bit we, input logic [7:0] wd);
    @(negedge clk);
    strb = s; sp_wr_en = we; sp_wr_data = wd;
    @(negedge clk);
    strb = 0; sp_wr_en = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_sp(input logic [7:0] v);
    issue(6'b0, 1'b1, v);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 4'((i * 7 + 3) & 15);
    repeat (3) @(negedge clk);
    chk(sp_rd_data == 8'h00 && !busy, "R1", "reset state", {sp_rd_data, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: call from SP=00 lands first nibble at FFh (R3)
    pc_in = 15'h5A3C; psw_in = 8'hA5; smb_in = 4'h9; srb_in = 4'h3;
    issue(6'b010000, 0, 0);
    // R5 interrupt
    pc_in = 15'h7FFF;
    issue(6'b100000, 0, 0);
    // R8 push SB
    issue(6'b000010, 0, 0);
    // R10: strobes and SP write during a busy call window
    pc_in = 15'h1234;
    @(negedge clk); strb = 6'b010000;
    @(negedge clk); strb = 6'b000100; sp_wr_en = 1; sp_wr_data = 8'h44;
    @(negedge clk); strb = 6'b100000;
    @(negedge clk); strb = 0; sp_wr_en = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    // unwind: R6 ret, R8 pop SB, R7 reti, R6 ret
    issue(6'b000100, 0, 0);
    issue(6'b000001, 0, 0);
    issue(6'b001000, 0, 0);
    issue(6'b000100, 0, 0);
    // R1: odd write value is stored even
    set_sp(8'h37);
    chk(sp_rd_data == 8'h36, "R1", "odd write", sp_rd_data, 8'h36);
    // R11 priorities
    issue(6'b110000, 0, 0);
    issue(6'b011100, 0, 0);
    issue(6'b000011, 0, 0);
    issue(6'b000001, 1, 8'h80);
    // R6 padding bit ignored: mem[13h] has bit 3 set
    set_sp(8'h10);
    issue(6'b000100, 0, 0);
    // R3 wrap below 00h and pop wrap above FFh
    set_sp(8'h02);
    pc_in = 15'h6ABC;
    issue(6'b010000, 0, 0);
    issue(6'b000100, 0, 0);
    set_sp(8'hFE);
    issue(6'b001000, 0, 0);
    // mixed sweep
    for (int i = 0; i < 24; i++) begin
      pc_in = 15'(i * 1237 + 5); psw_in = 8'(i * 29); smb_in = 4'(i); srb_in = 4'(~i);
      issue(6'(1 << (i % 6)), 0, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule